// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core with Late-Write Buffer

This block models a single-data-rate synchronous SRAM core for simulation and integration. Address, command and chip-select pins are captured on every rising clock edge. A read beat returns its word one cycle after it is registered. A write beat takes its data two cycles after its command. Written words pass through two buffer entries before they reach the array. Any read that touches a buffered or still-arriving word is served from the newest source for each 9-bit lane, so a read always sees the latest write.

A command may start a linear burst of one to four beats. The burst steps the low two address bits modulo four and leaves the upper bits alone. Each 9-bit lane of a written word has its own enable. A group of chip-select pins, compared against a matching set of polarity straps, lets two or four cores share one bus.

Data moves with fixed timing, so no handshake is involved. The core can take one command per cycle, but only when no burst is running. A command offered while a burst still has beats left is dropped, and there is no ready signal to push back, so the host must space its commands. `rd_oe` acts as the valid flag for read data. The host cannot stall it, and it holds for exactly one cycle for each read beat.

Top module: `dlw_sram_core`

## Requirements
- R1: A command is accepted at a rising edge when `cmd_valid` is 1, the core is selected and no burst beats remain. `cmd_write`, `cmd_addr`, `cmd_blen` and `cs_in` are sampled only at that edge.
- R2: When a read beat is registered at edge n, `rd_oe` is 1 and `rd_data` holds that beat's word during the cycle that follows edge n+1.
- R3: When a write beat is registered at edge n, its word is taken from `wr_data` and its lane enables from `wr_be`, both sampled at edge n+2.
- R4: `cmd_blen` gives the burst length minus one (0 gives 1 beat, 3 gives 4 beats). Beat j uses the upper bits of `cmd_addr` with low bits equal to (`cmd_addr[1:0]` + j) mod 4.
- R5: While a burst has beats remaining, `cmd_valid` is ignored, and no extra read or write beat comes from it.
- R6: `wr_be[i]` = 1 writes lane i, which is bits [9i+8:9i]. A lane whose enable is 0 keeps its previous content.
- R7: A read returns the latest write to its address that was commanded before it. This holds whether that word sits in the array, in either buffer entry, or is arriving at the same edge.
- R8: When several pending writes hit the read address, each lane is taken from the newest one that enabled that lane. Lanes that none of them enabled come from the array.
- R9: The core is selected only when every bit of `cs_in` equals the matching bit of `cs_pol`.
- R10: In any cycle that carries no read beat, `rd_oe` is 0. Buffered writes still move into the array during deselected and idle cycles.
- R11: While and after reset, `rd_oe` is 0 and no burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Start word address |
| cmd_blen | input | 2 | Burst length minus one |
| cs_in | input | NCS | Chip-select pins |
| cs_pol | input | NCS | Polarity strap per chip-select pin |
| wr_data | input | DW | Write word, two cycles after its beat |
| wr_be | input | DW/9 | Per-lane write enables, sampled with `wr_data` |
| rd_data | output | DW | Read word |
| rd_oe | output | 1 | Read data valid; bus would be driven |

## Verification
The hardest case to reach from the pins is a read issued right after a write to the same address. The write's word is only arriving on `wr_data` at the edge where the read result is registered, so it must be forwarded from the pins. A second hard case is a read that overlaps two buffered writes with different lane masks. The stimulus places single-beat writes and reads at gaps of zero to four cycles, so that each source in turn is the one that must win: the arriving word, each buffer entry, and the array. A back-to-back pair of partial writes then checks the lane-by-lane merge. Dropped commands are tested by offering a read in the middle of a write burst and checking that `rd_oe` stays low.

// File: rtl/dlw_sram_pkg.sv
package dlw_sram_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    BURST_1 = 2'd0,
    BURST_2 = 2'd1,
    BURST_3 = 2'd2,
    BURST_4 = 2'd3
  } burst_code_e;

  // step inside an aligned group of four words
  function automatic logic [1:0] wrap_step(input logic [1:0] low);
    return low + 2'd1;
  endfunction
endpackage

// File: rtl/dlw_burst_seq.sv
module dlw_burst_seq #(
  parameter int AW  = 6,
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic           cmd_write,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [1:0]     cmd_blen,
  input  logic [NCS-1:0] cs_in,
  input  logic [NCS-1:0] cs_pol,
  output logic           beat_vld,
  output logic           beat_wr,
  output logic [AW-1:0]  beat_addr,
  output logic [1:0]     beat_left
);
  import dlw_sram_pkg::*;

  logic selected;
  logic take;

  assign selected = &(cs_in ~^ cs_pol);
  assign take     = cmd_valid && selected && (beat_left == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_vld  <= 1'b0;
      beat_wr   <= 1'b0;
      beat_addr <= '0;
      beat_left <= 2'd0;
    end else if (take) begin
      beat_vld  <= 1'b1;
      beat_wr   <= cmd_write;
      beat_addr <= cmd_addr;
      beat_left <= cmd_blen;
    end else if (beat_left != 2'd0) begin
      beat_vld  <= 1'b1;
      beat_addr <= {beat_addr[AW-1:2], wrap_step(beat_addr[1:0])};
      beat_left <= beat_left - 2'd1;
    end else begin
      beat_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/dlw_write_buf.sv
module dlw_write_buf #(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int LANES = DW / 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_vld,
  input  logic             beat_wr,
  input  logic [AW-1:0]    beat_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_be,
  input  logic [DW-1:0]    arr_q,
  output logic [DW-1:0]    fwd_data,
  output logic             commit_en,
  output logic [AW-1:0]    commit_addr,
  output logic [DW-1:0]    commit_data,
  output logic [LANES-1:0] commit_be
);
  import dlw_sram_pkg::*;

  localparam int NENT = 2;

  // stage awaiting its data on the pins
  logic             w1_vld;
  logic [AW-1:0]    w1_addr;
  // buffered entries: index 0 newest
  logic [NENT-1:0]  e_vld;
  logic [AW-1:0]    e_addr [NENT];
  logic [DW-1:0]    e_data [NENT];
  logic [LANES-1:0] e_be   [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w1_vld  <= 1'b0;
      w1_addr <= '0;
      e_vld   <= '0;
      for (int i = 0; i < NENT; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
        e_be[i]   <= '0;
      end
    end else begin
      w1_vld    <= beat_vld && beat_wr;
      w1_addr   <= beat_addr;
      e_vld[0]  <= w1_vld;
      e_addr[0] <= w1_addr;
      e_data[0] <= wr_data;
      e_be[0]   <= wr_be;
      for (int i = 1; i < NENT; i++) begin
        e_vld[i]  <= e_vld[i-1];
        e_addr[i] <= e_addr[i-1];
        e_data[i] <= e_data[i-1];
        e_be[i]   <= e_be[i-1];
      end
    end
  end

  assign commit_en   = e_vld[NENT-1];
  assign commit_addr = e_addr[NENT-1];
  assign commit_data = e_data[NENT-1];
  assign commit_be   = e_be[NENT-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_comb begin
      lane_q = arr_q[l*LANE_W +: LANE_W];
      for (int i = NENT - 1; i >= 0; i--) begin
        if (e_vld[i] && (e_addr[i] == beat_addr) && e_be[i][l])
          lane_q = e_data[i][l*LANE_W +: LANE_W];
      end
      if (w1_vld && (w1_addr == beat_addr) && wr_be[l])
        lane_q = wr_data[l*LANE_W +: LANE_W];
    end
    assign fwd_data[l*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/dlw_word_array.sv
module dlw_word_array #(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int LANES = DW / 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wbe,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  import dlw_sram_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && wbe[l])
        mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dlw_sram_core.sv
module dlw_sram_core #(
  parameter int DW  = 36,
  parameter int AW  = 6,
  parameter int NCS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [1:0]        cmd_blen,
  input  logic [NCS-1:0]    cs_in,
  input  logic [NCS-1:0]    cs_pol,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW/9-1:0]   wr_be,
  output logic [DW-1:0]     rd_data,
  output logic              rd_oe
);
  localparam int LANES = DW / 9;

  logic             beat_vld;
  logic             beat_wr;
  logic [AW-1:0]    beat_addr;
  logic [1:0]       beat_left;
  logic [DW-1:0]    arr_q;
  logic [DW-1:0]    fwd_data;
  logic             commit_en;
  logic [AW-1:0]    commit_addr;
  logic [DW-1:0]    commit_data;
  logic [LANES-1:0] commit_be;

  dlw_burst_seq #(.AW(AW), .NCS(NCS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_blen  (cmd_blen),
    .cs_in     (cs_in),
    .cs_pol    (cs_pol),
    .beat_vld  (beat_vld),
    .beat_wr   (beat_wr),
    .beat_addr (beat_addr),
    .beat_left (beat_left)
  );

  dlw_write_buf #(.AW(AW), .DW(DW), .LANES(LANES)) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_vld    (beat_vld),
    .beat_wr     (beat_wr),
    .beat_addr   (beat_addr),
    .wr_data     (wr_data),
    .wr_be       (wr_be),
    .arr_q       (arr_q),
    .fwd_data    (fwd_data),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .commit_be   (commit_be)
  );

  dlw_word_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
    .clk   (clk),
    .we    (commit_en),
    .waddr (commit_addr),
    .wdata (commit_data),
    .wbe   (commit_be),
    .raddr (beat_addr),
    .rdata (arr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_oe <= beat_vld && !beat_wr;
      if (beat_vld && !beat_wr)
        rd_data <= fwd_data;
    end
  end
endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk #(
  parameter int AW  = 6,
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic [NCS-1:0] cs_in,
  input logic [NCS-1:0] cs_pol,
  input logic           beat_vld,
  input logic           beat_wr,
  input logic [AW-1:0]  beat_addr,
  input logic [1:0]     beat_left,
  input logic           commit_en,
  input logic           rd_oe
);
  // R2
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_wr) |=> rd_oe);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_vld && !beat_wr) |=> !rd_oe);

  // R4
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_left != 2'd0) |=>
      (beat_vld && beat_addr[1:0] == $past(beat_addr[1:0]) + 2'd1
       && beat_addr[AW-1:2] == $past(beat_addr[AW-1:2])));

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_left != 2'd0) |=> (beat_wr == $past(beat_wr) && beat_left == $past(beat_left) - 2'd1));

  // R9
  desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cs_in != cs_pol && beat_left == 2'd0) |=> !beat_vld);

  // R3
  write_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_wr) |=> ##2 commit_en);
endmodule

bind dlw_sram_core dlw_sram_chk #(.AW(AW), .NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cs_in     (cs_in),
  .cs_pol    (cs_pol),
  .beat_vld  (beat_vld),
  .beat_wr   (beat_wr),
  .beat_addr (beat_addr),
  .beat_left (beat_left),
  .commit_en (commit_en),
  .rd_oe     (rd_oe)
);

// File: tb/dlw_sram_core_tb_top.sv
module dlw_sram_core_tb_top;
  localparam int DW    = 36;
  localparam int AW    = 6;
  localparam int NCS   = 2;
  localparam int LANES = DW / 9;
  localparam int SLOTS = 256;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid;
  logic             cmd_write;
  logic [AW-1:0]    cmd_addr;
  logic [1:0]       cmd_blen;
  logic [NCS-1:0]   cs_in;
  logic [NCS-1:0]   cs_pol;
  logic [DW-1:0]    wr_data;
  logic [LANES-1:0] wr_be;
  logic [DW-1:0]    rd_data;
  logic             rd_oe;

  always #2 clk = ~clk;

  dlw_sram_core #(.DW(DW), .AW(AW), .NCS(NCS)) dut_i (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_write (cmd_write),
    .cmd_addr (cmd_addr), .cmd_blen (cmd_blen), .cs_in (cs_in), .cs_pol (cs_pol),
    .wr_data (wr_data), .wr_be (wr_be), .rd_data (rd_data), .rd_oe (rd_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_until = -1;

  logic [DW-1:0]    ref_mem  [1 << AW];
  logic [DW-1:0]    s_din    [SLOTS];
  logic [LANES-1:0] s_be     [SLOTS];
  logic             s_oe     [SLOTS];
  logic [DW-1:0]    s_dat    [SLOTS];
  string            s_tag    [SLOTS];

  // one negedge: check outputs of the previous edge, then drive this cycle
  task automatic tick();
    int s;
    @(negedge clk);
    cyc++;
    s = cyc % SLOTS;
    checks++;
    if (rd_oe !== s_oe[s]) begin
      errors++;
      $display("FAIL %s cycle %0d: rd_oe=%0b expected %0b", s_tag[s], cyc, rd_oe, s_oe[s]);
    end else if (s_oe[s]) begin
      checks++;
      if (rd_data !== s_dat[s]) begin
        errors++;
        $display("FAIL %s cycle %0d: rd_data=%h expected %h", s_tag[s], cyc, rd_data, s_dat[s]);
      end
    end
    wr_data   = s_din[s];
    wr_be     = s_be[s];
    s_oe[s]   = 1'b0;
    s_tag[s]  = "R10";
    s_din[s]  = '0;
    s_be[s]   = '0;
    cmd_valid = 1'b0;
    cs_in     = cs_pol;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // offer a command this cycle; plan its beats from R1, R3, R4, R5, R9
  task automatic cmd(input bit w, input int a, input int blen, input logic [DW-1:0] seed,
                     input logic [LANES-1:0] be, input logic [NCS-1:0] csx, input string tag);
    cmd_valid = 1'b1;
    cmd_write = w;
    cmd_addr  = AW'(a);
    cmd_blen  = 2'(blen);
    cs_in     = cs_pol ^ csx;
    if (csx == '0 && cyc > busy_until) begin
      busy_until = cyc + blen;
      for (int j = 0; j <= blen; j++) begin
        int ad = (a & ~3) | ((a + j) & 3);
        int s  = (cyc + j + 2) % SLOTS;
        if (w) begin
          s_din[s] = seed + DW'(j);
          s_be[s]  = be;
          for (int l = 0; l < LANES; l++)
            if (be[l]) ref_mem[ad][l*9 +: 9] = s_din[s][l*9 +: 9];
        end else begin
          s_oe[s]  = 1'b1;
          s_dat[s] = ref_mem[ad];
          s_tag[s] = tag;
        end
      end
    end
    tick();
  endtask

  // R11: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      s_oe[i] = 1'b0; s_din[i] = '0; s_be[i] = '0; s_tag[i] = "R11"; s_dat[i] = '0;
    end
    cs_pol = 2'b10;
    cs_in = cs_pol; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_blen = '0;
    wr_data = '0; wr_be = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  // R1 R3 R4 R2: burst fill, then wrapped read bursts of each length
  task automatic t_bursts();
    for (int k = 0; k < 6; k++) begin
      cmd(1, k * 4, 3, 36'h1_0000_0100 + DW'(k * 16), '1, '0, "R3");
      idle(3);
    end
    cmd(0, 5, 3, '0, '0, '0, "R4"); idle(3);
    cmd(0, 14, 2, '0, '0, '0, "R4"); idle(2);
    cmd(0, 3, 1, '0, '0, '0, "R4"); idle(1);
    cmd(0, 10, 0, '0, '0, '0, "R2");
    cmd(0, 11, 0, '0, '0, '0, "R1");
    idle(3);
  endtask

  // R7: read after write at gaps 0..4 (pins, both entries, array)
  task automatic t_forward();
    for (int g = 0; g <= 4; g++) begin
      cmd(1, 32 + g, 0, 36'hA_5A5A_0000 + DW'(g), '1, '0, "R7");
      idle(g);
      cmd(0, 32 + g, 0, '0, '0, '0, "R7");
      idle(3);
    end
  endtask

  // R6 R8: partial lanes and newest-wins merge
  task automatic t_lanes();
    cmd(1, 1, 0, 36'h9_8765_4321, 4'b0101, '0, "R6"); idle(3);
    cmd(0, 1, 0, '0, '0, '0, "R6"); idle(3);
    cmd(1, 2, 0, 36'h1_1111_1111, 4'b0011, '0, "R8");
    cmd(1, 2, 0, 36'h2_2222_2222, 4'b0110, '0, "R8");
    cmd(0, 2, 0, '0, '0, '0, "R8");
    cmd(0, 2, 0, '0, '0, '0, "R8");
    idle(2);
    cmd(0, 2, 0, '0, '0, '0, "R8"); idle(3);
  endtask

  // R5: a read offered mid write-burst is dropped
  task automatic t_busy();
    cmd(1, 24, 3, 36'h3_3300_0000, '1, '0, "R5");
    cmd(0, 25, 0, '0, '0, '0, "R5");
    cmd(0, 26, 0, '0, '0, '0, "R5");
    idle(4);
    cmd(0, 24, 3, '0, '0, '0, "R5"); idle(5);
  endtask

  // R9 R10: select polarity, deselected cycles, retire during deselect
  task automatic t_select();
    cmd(0, 5, 0, '0, '0, 2'b01, "R9");
    cmd(0, 5, 0, '0, '0, 2'b10, "R9");
    cmd(0, 5, 0, '0, '0, 2'b11, "R9");
    cmd(0, 5, 0, '0, '0, 2'b00, "R9");
    idle(2);
    cmd(1, 40, 0, 36'h4_0404_0404, '1, '0, "R10");
    for (int i = 0; i < 5; i++) cmd(0, 40, 0, '0, '0, 2'b11, "R10");
    cmd(0, 40, 0, '0, '0, '0, "R10"); idle(3);
    cs_pol = 2'b01;
    cmd(0, 6, 0, '0, '0, '0, "R9");
    cmd(0, 6, 0, '0, '0, 2'b01, "R9");
    idle(3);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bursts();
    t_forward();
    t_lanes();
    t_busy();
    t_select();
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule